// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps a running calendar in packed BCD: seconds, minutes, hours, day of week, day of month, month with a century flag, and a two-digit year. A free-running enable at the crystal rate feeds a parameterised binary prescaler. The prescaler issues one tick per second, and each tick advances the calendar by one second. Carries ripple through the fields in the same clock edge. The hour field holds its own 12/24-hour mode bit. The date field knows each month's length and the leap-year rule.

Software or a bus front end loads any field through a one-hot write strobe and a shared data byte. A write to the seconds field restarts the prescaler, so the following second is a full second long. A one-cycle pulse marks each completed second, so that alarm comparison logic placed after this block can sample the new time. A run enable freezes both the prescaler and the calendar.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01 with the century bit 0, and year 0x00. `sec_pulse` is 0.
- R2: Seconds and minutes count in packed BCD from 0x00 to 0x59. A seconds wrap carries into minutes, and a minutes wrap carries into hours. `sec_pulse` is high for exactly the one cycle in which the newly incremented seconds value first appears.
- R3: When hours bit 6 is 0, hours bits 5:0 count in BCD from 0x00 to 0x23, and the step from 0x23 to 0x00 advances the day.
- R4: When hours bit 6 is 1, bits 4:0 hold 1 to 12 in BCD and bit 5 is PM (1 = PM). The step from 11 to 12 toggles bit 5. The step from 12 to 1 leaves bit 5 unchanged. Only the step from 11 PM to 12 AM advances the day.
- R5: Day of week (field index 3) advances by one at each day advance and wraps from 7 to 1.
- R6: The date wraps to 0x01 after the month's last day: 0x30 for months 0x04, 0x06, 0x09 and 0x11, 0x31 for the other months except February, and 0x28 or 0x29 for month 0x02. The wrap advances the month.
- R7: A year is a leap year exactly when its two BCD digits form a number divisible by four, 00 included.
- R8: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00 and toggles month bit 7, the century bit.
- R9: A write to seconds (`wr_en` bit 0) restarts the prescaler. The next increment lands on the 2^DIV_BITS-th enabled oscillator tick after the write edge.
- R10: While `run_en` is 0 the prescaler and the calendar hold their values, and writes still take effect.
- R11: A write to a field in the same cycle as an increment of that field wins. A seconds write in a tick cycle also cancels that tick and its `sec_pulse`.
- R12: With `run_en` high, one second passes per 2^DIV_BITS `osc_tick` pulses, however those pulses are spaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Crystal-rate enable pulse |
| run_en | input | 1 | Counting enable; 0 freezes prescaler and calendar |
| wr_en | input | 7 | One-hot field write strobe: 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 year |
| wr_data | input | 8 | Packed BCD value for the strobed field |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with mode bit 6 and PM bit 5 |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month with century flag in bit 7 |
| year_o | output | 8 | Year |
| sec_pulse | output | 1 | One-cycle pulse on each seconds increment |

## Verification
The bench goes after the hour boundaries in both modes. A design that toggled PM on the step from 12 to 1 would report noon as 12 AM. One that advanced the day at 11 AM would double the date rate.

February is checked for every year from 00 to 99, and every month is checked in one leap year and one common year. A wrong month table would skip day 31 or invent a day 32. A faulty leap test would drop February 29 in year 00 or allow it in year 02.

The restart and priority cases are checked to the cycle. A design that did not clear the prescaler on a seconds write would tick early. One that let an increment override a write would show a field one step past the written value. The bench also checks the century toggle in both directions.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int NFIELDS = 7;

   typedef enum int {
      F_SEC   = 0,
      F_MIN   = 1,
      F_HOUR  = 2,
      F_DOW   = 3,
      F_DATE  = 4,
      F_MONTH = 5,
      F_YEAR  = 6
   } field_e;

   localparam logic [7:0] M_SEC   = 8'h7F;
   localparam logic [7:0] M_MIN   = 8'h7F;
   localparam logic [7:0] M_HOUR  = 8'h7F;
   localparam logic [7:0] M_DOW   = 8'h07;
   localparam logic [7:0] M_DATE  = 8'h3F;
   localparam logic [7:0] M_MONTH = 8'h9F;
   localparam logic [7:0] M_YEAR  = 8'hFF;

   // add one to a two-digit packed BCD value (no wrap handling)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [3:0] tens;
      tens = v[7:4] + 4'd1;
      if (v[3:0] == 4'd9) return {tens, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // 10 = 2 (mod 4), so the year mod 4 equals (2*tens + ones) mod 4
   function automatic logic is_leap(input logic [7:0] y);
      logic [5:0] s;
      s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
      case (m)
         5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int DIV_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic run_en,
   input  logic restart,
   output logic tick_o
);

   generate
      if (DIV_BITS > 24) begin : g_bad
         $error("cal_prescaler: DIV_BITS above 24 not supported");
      end

      if (DIV_BITS == 0) begin : g_bypass
         assign tick_o = osc_tick & run_en;
      end else begin : g_count
         localparam logic [DIV_BITS-1:0] LAST = {DIV_BITS{1'b1}};
         logic [DIV_BITS-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)                   cnt_q <= '0;
            else if (restart)             cnt_q <= '0;
            else if (run_en && osc_tick)  cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = run_en & osc_tick & (cnt_q == LAST);

         // R9: a restart leaves no tick in the following cycle
         a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> !tick_o);
         // R10: prescaler frozen while halted
         a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_en && !restart) |=> (cnt_q == $past(cnt_q)));
      end
   endgenerate

endmodule

// File: rtl/cal_time_unit.sv
module cal_time_unit
   import cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wr_sec,
   input  logic       wr_min,
   input  logic       wr_hour,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_q,
   output logic [7:0] min_q,
   output logic [7:0] hour_q,
   output logic       sec_pulse,
   output logic       day_carry
);

   logic       step;
   logic       min_step;
   logic       hr_step;
   logic [7:0] hour_nx;
   logic [7:0] hinc;
   logic       end_of_day;

   assign step     = tick & ~wr_sec;
   assign min_step = step & (sec_q == 8'h59);
   assign hr_step  = min_step & (min_q == 8'h59);
   assign hinc     = bcd_inc({2'b00, hour_q[5:0]});

   always_comb begin
      hour_nx    = hour_q;
      end_of_day = 1'b0;
      if (hour_q[6]) begin
         if (hour_q[4:0] == 5'h11) begin
            hour_nx    = {hour_q[7:6], ~hour_q[5], 5'h12};
            end_of_day = hour_q[5];
         end else if (hour_q[4:0] == 5'h12) begin
            hour_nx = {hour_q[7:5], 5'h01};
         end else begin
            hour_nx = {hour_q[7:5], hinc[4:0]};
         end
      end else begin
         if (hour_q[5:0] == 6'h23) begin
            hour_nx    = {hour_q[7:6], 6'h00};
            end_of_day = 1'b1;
         end else begin
            hour_nx = {hour_q[7:6], hinc[5:0]};
         end
      end
   end

   assign day_carry = hr_step & end_of_day;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q     <= 8'h00;
         min_q     <= 8'h00;
         hour_q    <= 8'h00;
         sec_pulse <= 1'b0;
      end else begin
         sec_pulse <= step;
         if (wr_sec)        sec_q <= wr_data & M_SEC;
         else if (step)     sec_q <= (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);
         if (wr_min)        min_q <= wr_data & M_MIN;
         else if (min_step) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
         if (wr_hour)       hour_q <= wr_data & M_HOUR;
         else if (hr_step)  hour_q <= hour_nx;
      end
   end

   // R2: the pulse always accompanies a fresh seconds value
   a_r2_pulse_new_value: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> (sec_q != $past(sec_q)));
   // R11: a minutes write wins over a coincident carry
   a_r11_min_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_min |=> (min_q == ($past(wr_data) & M_MIN)));
   // R11: a seconds write cancels that cycle's pulse
   a_r11_sec_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sec |=> !sec_pulse);
   // R4: 12 -> 1 keeps the PM bit
   a_r4_noon_keeps_pm: assert property (@(posedge clk) disable iff (!rst_n)
      (hr_step && !wr_hour && hour_q[6] && hour_q[4:0] == 5'h12)
      |=> (hour_q[4:0] == 5'h01 && hour_q[5] == $past(hour_q[5])));

endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
   import cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       day_carry,
   input  logic       wr_dow,
   input  logic       wr_date,
   input  logic       wr_month,
   input  logic       wr_year,
   input  logic [7:0] wr_data,
   output logic [7:0] dow_q,
   output logic [7:0] date_q,
   output logic [7:0] month_q,
   output logic [7:0] year_q
);

   logic       month_end;
   logic       mon_step;
   logic       yr_step;
   logic       century_flip;
   logic [7:0] minc;

   assign month_end    = (date_q[5:0] == month_last(month_q[4:0], year_q));
   assign mon_step     = day_carry & month_end;
   assign yr_step      = mon_step & (month_q[4:0] == 5'h12);
   assign century_flip = yr_step & (year_q == 8'h99);
   assign minc         = bcd_inc({3'b000, month_q[4:0]});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dow_q   <= 8'h01;
         date_q  <= 8'h01;
         month_q <= 8'h01;
         year_q  <= 8'h00;
      end else begin
         if (wr_dow)         dow_q <= wr_data & M_DOW;
         else if (day_carry) dow_q <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01;

         if (wr_date)        date_q <= wr_data & M_DATE;
         else if (day_carry) date_q <= month_end ? 8'h01 : bcd_inc(date_q);

         if (wr_month)       month_q <= wr_data & M_MONTH;
         else if (mon_step)  month_q <= {month_q[7] ^ century_flip, 2'b00,
                                         (month_q[4:0] == 5'h12) ? 5'h01 : minc[4:0]};

         if (wr_year)        year_q <= wr_data & M_YEAR;
         else if (yr_step)   year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
      end
   end

   // R8: year wrap toggles the century bit
   a_r8_century_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (century_flip && !wr_month) |=> (month_q[7] != $past(month_q[7])));
   // R5: day of week wraps 7 -> 1
   a_r5_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (day_carry && !wr_dow && dow_q == 8'h07) |=> (dow_q == 8'h01));
   // R6: date never moves without a day carry or a write
   a_r6_date_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!day_carry && !wr_date) |=> $stable(date_q));

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
   import cal_pkg::*;
#(
   parameter int DIV_BITS = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               osc_tick,
   input  logic               run_en,
   input  logic [NFIELDS-1:0] wr_en,
   input  logic [7:0]         wr_data,
   output logic [7:0]         sec_o,
   output logic [7:0]         min_o,
   output logic [7:0]         hour_o,
   output logic [7:0]         dow_o,
   output logic [7:0]         date_o,
   output logic [7:0]         month_o,
   output logic [7:0]         year_o,
   output logic               sec_pulse
);

   logic tick;
   logic day_carry;

   cal_prescaler #(.DIV_BITS(DIV_BITS)) i_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_tick (osc_tick),
      .run_en   (run_en),
      .restart  (wr_en[F_SEC]),
      .tick_o   (tick)
   );

   cal_time_unit i_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_sec    (wr_en[F_SEC]),
      .wr_min    (wr_en[F_MIN]),
      .wr_hour   (wr_en[F_HOUR]),
      .wr_data   (wr_data),
      .sec_q     (sec_o),
      .min_q     (min_o),
      .hour_q    (hour_o),
      .sec_pulse (sec_pulse),
      .day_carry (day_carry)
   );

   cal_date_unit i_date (
      .clk       (clk),
      .rst_n     (rst_n),
      .day_carry (day_carry),
      .wr_dow    (wr_en[F_DOW]),
      .wr_date   (wr_en[F_DATE]),
      .wr_month  (wr_en[F_MONTH]),
      .wr_year   (wr_en[F_YEAR]),
      .wr_data   (wr_data),
      .dow_q     (dow_o),
      .date_q    (date_o),
      .month_q   (month_o),
      .year_q    (year_o)
   );

   // R10: halted with no write, seconds hold
   a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && wr_en == '0) |=> $stable(sec_o));
   // R2: minutes move only by write or seconds carry
   a_r2_min_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en[F_MIN] && !(tick && !wr_en[F_SEC] && sec_o == 8'h59)) |=> $stable(min_o));

endmodule

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;

   localparam int DIVB = 2;
   localparam int PER  = 1 << DIVB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b1;
   logic       run_en = 1'b0;
   logic [6:0] wr_en = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
   logic       sec_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bcd_calendar_core #(.DIV_BITS(DIVB)) i_bcd_calendar_core (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run_en(run_en),
      .wr_en(wr_en), .wr_data(wr_data),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
      .date_o(date_o), .month_o(month_o), .year_o(year_o), .sec_pulse(sec_pulse)
   );

   function automatic logic [7:0] bcd(input int b);
      return 8'(((b / 10) << 4) | (b % 10));
   endfunction

   function automatic int last_day(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk);
      wr_en = 7'(1 << idx);
      wr_data = d;
      @(negedge clk);
      wr_en = '0;
   endtask

   // loads all fields with the calendar halted, then writes seconds (restart)
   task automatic set_all(input logic [7:0] s, m, h, dw, dt, mo, y);
      run_en = 1'b0;
      wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
      @(negedge clk);
      run_en = 1'b1;
      wr_en = 7'b0000001;
      wr_data = s;
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic adv(input int n);
      repeat (PER * n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sec", sec_o, 8'h00);   chk("R1 min", min_o, 8'h00);
      chk("R1 hour", hour_o, 8'h00); chk("R1 dow", dow_o, 8'h01);
      chk("R1 date", date_o, 8'h01); chk("R1 month", month_o, 8'h01);
      chk("R1 year", year_o, 8'h00); chk("R1 pulse", {7'd0, sec_pulse}, 8'h00);

      // R2 sweep of one full hour, second by second
      set_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      for (int i = 1; i <= 3600; i++) begin
         adv(1);
         chk("R2 sec", sec_o, bcd(i % 60));
         chk("R2 min", min_o, bcd((i / 60) % 60));
      end
      chk("R2 hour carry", hour_o, 8'h01);

      // R2 pulse timing, R9 restart timing
      set_all(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      repeat (PER - 1) @(posedge clk);
      @(negedge clk);
      chk("R9 not early", sec_o, 8'h05);
      chk("R2 no pulse yet", {7'd0, sec_pulse}, 8'h00);
      @(posedge clk); @(negedge clk);
      chk("R9 on time", sec_o, 8'h06);
      chk("R2 pulse", {7'd0, sec_pulse}, 8'h01);
      @(posedge clk); @(negedge clk);
      chk("R2 pulse one cycle", {7'd0, sec_pulse}, 8'h00);

      // R9 restart in mid count
      set_all(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      repeat (2) @(posedge clk);
      wr(0, 8'h20);
      repeat (PER - 1) @(posedge clk);
      @(negedge clk);
      chk("R9 restart late", sec_o, 8'h20);
      @(posedge clk); @(negedge clk);
      chk("R9 restart tick", sec_o, 8'h21);

      // R11 seconds write in tick cycle
      set_all(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      repeat (PER - 1) @(posedge clk);
      wr(0, 8'h30);
      chk("R11 sec write wins", sec_o, 8'h30);
      chk("R11 tick cancelled", {7'd0, sec_pulse}, 8'h00);

      // R11 minutes write against carry
      set_all(8'h59, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      repeat (PER - 1) @(posedge clk);
      wr(1, 8'h42);
      chk("R11 sec wrapped", sec_o, 8'h00);
      chk("R11 min write wins", min_o, 8'h42);

      // R10 halt
      set_all(8'h15, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      repeat (2) @(posedge clk);
      @(negedge clk);
      run_en = 1'b0;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R10 sec frozen", sec_o, 8'h15);
      wr(1, 8'h33);
      chk("R10 write while halted", min_o, 8'h33);
      run_en = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R10 prescaler held", sec_o, 8'h15);
      @(posedge clk); @(negedge clk);
      chk("R10 resume", sec_o, 8'h16);

      // R12 sparse oscillator enables
      set_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
      begin
         int np = 0;
         for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (sec_pulse) np++;
            osc_tick = (i % 2 == 0);
         end
         chk("R12 pulse count", 8'(np), 8'd10);
      end
      osc_tick = 1'b1;

      // R3 24-hour sweep
      for (int h = 0; h < 24; h++) begin
         set_all(8'h59, 8'h59, bcd(h), 8'h03, 8'h10, 8'h05, 8'h21);
         adv(1);
         chk("R3 hour", hour_o, bcd((h + 1) % 24));
         chk("R3 day", date_o, (h == 23) ? 8'h11 : 8'h10);
         chk("R5 dow", dow_o, (h == 23) ? 8'h04 : 8'h03);
      end

      // R4 12-hour sweep
      for (int pm = 0; pm < 2; pm++) begin
         for (int h = 1; h <= 12; h++) begin
            int nh; int npm; bit nd;
            nh = (h == 12) ? 1 : h + 1;
            npm = (h == 11) ? 1 - pm : pm;
            nd = (h == 11 && pm == 1);
            set_all(8'h59, 8'h59, 8'h40 | 8'(pm << 5) | bcd(h), 8'h02, 8'h10, 8'h05, 8'h21);
            adv(1);
            chk("R4 hour", hour_o, 8'h40 | 8'(npm << 5) | bcd(nh));
            chk("R4 day", date_o, nd ? 8'h11 : 8'h10);
         end
      end

      // R5 day-of-week wrap
      set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h05, 8'h21);
      adv(1);
      chk("R5 wrap", dow_o, 8'h01);

      // R6 R7 February in every year
      for (int y = 0; y < 100; y++) begin
         int ld;
         ld = last_day(2, y);
         set_all(8'h59, 8'h59, 8'h23, 8'h01, bcd(ld - 1), 8'h02, bcd(y));
         adv(1);
         chk("R7 feb reaches last", date_o, bcd(ld));
         set_all(8'h59, 8'h59, 8'h23, 8'h01, bcd(ld), 8'h02, bcd(y));
         adv(1);
         chk("R7 feb wraps", date_o, 8'h01);
         chk("R7 to march", month_o, 8'h03);
      end

      // R6 R8 every month in a leap and a common year
      for (int k = 0; k < 2; k++) begin
         int y;
         y = (k == 0) ? 24 : 21;
         for (int m = 1; m <= 12; m++) begin
            int ld;
            ld = last_day(m, y);
            set_all(8'h59, 8'h59, 8'h23, 8'h01, bcd(ld - 1), bcd(m), bcd(y));
            adv(1);
            chk("R6 reaches last", date_o, bcd(ld));
            set_all(8'h59, 8'h59, 8'h23, 8'h01, bcd(ld), bcd(m), bcd(y));
            adv(1);
            chk("R6 wraps", date_o, 8'h01);
            chk("R8 month", month_o, bcd(m == 12 ? 1 : m + 1));
            chk("R8 year", year_o, bcd(m == 12 ? y + 1 : y));
         end
      end

      // R8 century toggle both ways
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
      adv(1);
      chk("R8 year wrap", year_o, 8'h00);
      chk("R8 century set", month_o, 8'h81);
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h92, 8'h99);
      adv(1);
      chk("R8 century clear", month_o, 8'h01);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule